// File: doc/BRIEF.md
# Bus-Idle Sleep Mode Controller

This block chooses between an active and a low-power sleep mode for a battery monitor. It watches the synchronised logic levels of the two serial bus lines and a sleep-enable configuration bit. When the bit is set and both lines stay low for an unbroken window, the controller enters sleep. A bus that has been disconnected and pulled low by on-chip pulldowns therefore puts the monitor to sleep. When either line goes high, the controller leaves sleep straight away.

The window is timed in ticks of a prescaler driven by the system clock. `PRESCALE_DIV` sets the clock cycles per tick and `WINDOW_TICKS` sets the ticks per window. The defaults give a 2 s window from a 50 MHz clock. Define WIN_CYC = WINDOW_TICKS × PRESCALE_DIV.

The block drives two outputs:
- a sleep flag;
- a measurement-enable signal that gates the measurement sequencer and the charge accumulator.

Register access over the bus does not depend on this block and stays available in both modes.

Top module: `bus_idle_sleep_ctrl`

## Requirements
- R1: With `sleep_en_i`=1 and both `scl_i` and `sda_i` at 0, sampled on WIN_CYC+1 consecutive rising clock edges, `sleep_o` becomes 1 after the last of those edges. If only WIN_CYC such edges occur, `sleep_o` stays 0.
- R2: While `sleep_en_i` is 0, `sleep_o` never rises, however long both lines stay low.
- R3: When `sleep_o` is 1 and a rising edge samples `scl_i`=1 or `sda_i`=1, `sleep_o` is 0 after that edge.
- R4: Clearing `sleep_en_i` while asleep does not by itself wake the controller. `sleep_o` stays 1 while both lines remain low.
- R5: `meas_en_o` goes to 0 on the same edge on which `sleep_o` goes to 1. The two outputs are never 1 together.
- R6: `meas_en_o` returns to 1 one clock cycle after `sleep_o` returns to 0.
- R7: Any edge that samples a line high, or `sleep_en_i` low, while active restarts the low window from zero. A full WIN_CYC+1 qualifying edges are then needed again.
- R8: After synchronous reset, `sleep_o` is 0 and `meas_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised clock-line level |
| sda_i | input | 1 | Synchronised data-line level |
| sleep_en_i | input | 1 | Sleep-enable configuration bit (1 permits sleep) |
| sleep_o | output | 1 | 1 while in sleep mode |
| meas_en_o | output | 1 | 1 while measurements and accumulation may run |

## Verification
The bench goes after the exact length of the low window:
- It holds the lines low for WIN_CYC edges and then for WIN_CYC+1 edges. An off-by-one counter would sleep one cycle early or one cycle late.
- It inserts single-cycle high glitches and enable drops mid-window. A counter that failed to restart would enter sleep too soon.

While asleep, the bench clears the enable bit, which exposes a design that wakes on the enable instead of on the bus. It also wakes the controller once through each line. Throughout, it checks the one-cycle lag of the measurement enable behind the sleep flag: a design with that lag wrong would restart measurements while still flagged asleep, or leave them stopped too long.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic {
    MODE_ACTIVE = 1'b0,
    MODE_SLEEP  = 1'b1
  } pm_mode_t;
endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
  parameter int PRESCALE_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;

  // count restarts whenever the qualifying condition drops
  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

  a_r7_prescale_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (cnt_q == '0))
    else $error("R7: prescaler not restarted");
endmodule

// File: rtl/pm_window.sv
module pm_window #(
  parameter int WINDOW_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int TICK_W = $clog2(WINDOW_TICKS + 1);
  localparam logic [TICK_W-1:0] FULL = TICK_W'(WINDOW_TICKS);

  logic [TICK_W-1:0] ticks_q;

  // saturating tick counter for the low window
  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      ticks_q <= '0;
    end else if (tick_i && (ticks_q != FULL)) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  assign done_o = (ticks_q == FULL);

  a_r7_window_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> !done_o)
    else $error("R7: window not cleared");
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic bus_low_i,
  input  logic sleep_en_i,
  input  logic window_done_i,
  output logic sleep_o,
  output logic meas_en_o
);
  pm_mode_t mode_q;
  logic     meas_q;
  logic     enter;
  logic     wake;

  assign enter = (mode_q == MODE_ACTIVE) && sleep_en_i && bus_low_i && window_done_i;
  assign wake  = (mode_q == MODE_SLEEP) && !bus_low_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= MODE_ACTIVE;
      meas_q <= 1'b1;
    end else begin
      if (enter) begin
        mode_q <= MODE_SLEEP;
      end else if (wake) begin
        mode_q <= MODE_ACTIVE;
      end
      // measurement enable trails the wake by one cycle
      meas_q <= !enter && (mode_q == MODE_ACTIVE);
    end
  end

  assign sleep_o   = (mode_q == MODE_SLEEP);
  assign meas_en_o = meas_q;

  a_r3_wake_now: assert property (@(posedge clk_i) disable iff (rst_i)
    (sleep_o && !bus_low_i) |=> !sleep_o)
    else $error("R3: no wake");
  a_r2_disabled_stays_awake: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sleep_o && !sleep_en_i) |=> !sleep_o)
    else $error("R2: slept while disabled");
  a_r4_enable_clear_no_wake: assert property (@(posedge clk_i) disable iff (rst_i)
    (sleep_o && bus_low_i && !sleep_en_i) |=> sleep_o)
    else $error("R4: woke on enable clear");
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(sleep_o && meas_en_o))
    else $error("R5: both outputs high");
  a_r6_meas_returns: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sleep_o) |=> meas_en_o)
    else $error("R6: measurement enable late");
  a_r1_entry_needs_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sleep_o && !bus_low_i) |=> !sleep_o)
    else $error("R1: slept with a line high");
endmodule

// File: rtl/bus_idle_sleep_ctrl.sv
module bus_idle_sleep_ctrl #(
  parameter int PRESCALE_DIV = 50000,
  parameter int WINDOW_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sleep_en_i,
  output logic sleep_o,
  output logic meas_en_o
);
  logic bus_low;
  logic qualify;
  logic tick;
  logic window_done;
  logic sleep_int;

  assign bus_low = !scl_i && !sda_i;
  assign qualify = bus_low && sleep_en_i && !sleep_int;

  pm_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (qualify),
    .tick_o (tick)
  );

  pm_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_win (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (!qualify),
    .tick_i (tick),
    .done_o (window_done)
  );

  pm_mode_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .bus_low_i     (bus_low),
    .sleep_en_i    (sleep_en_i),
    .window_done_i (window_done),
    .sleep_o       (sleep_int),
    .meas_en_o     (meas_en_o)
  );

  assign sleep_o = sleep_int;
endmodule

// File: tb/bus_idle_sleep_ctrl_tb.sv
module bus_idle_sleep_ctrl_tb;
  localparam int DIV = 4;
  localparam int TICKS = 5;
  localparam int WIN = DIV * TICKS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic en  = 1'b0;
  logic sleep_w;
  logic meas_w;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  sl;
    logic  me;
    string tag;
  } exp_t;
  exp_t q[$];

  logic m_sleep = 1'b0;
  int   run = 0;

  always #10 clk = ~clk;

  bus_idle_sleep_ctrl #(.PRESCALE_DIV(DIV), .WINDOW_TICKS(TICKS)) u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .scl_i      (scl),
    .sda_i      (sda),
    .sleep_en_i (en),
    .sleep_o    (sleep_w),
    .meas_en_o  (meas_w)
  );

  task automatic check(input logic sl, input logic me, input string tag);
    checks++;
    if (sleep_w !== sl || meas_w !== me) begin
      errors++;
      $display("FAIL %s: sleep=%b meas=%b expected sleep=%b meas=%b", tag, sleep_w, meas_w, sl, me);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic cyc(input logic s, input logic d, input logic e, input string tag);
    logic low;
    logic nsl;
    logic nme;
    exp_t it;
    @(negedge clk);
    scl = s; sda = d; en = e;
    low = !s && !d;
    if (!m_sleep) begin
      nsl = (run == WIN) && e && low;
      nme = !nsl;
      if (nsl || !(e && low)) run = 0;
      else if (run < WIN) run++;
    end else begin
      nsl = low;
      nme = 1'b0;
      run = 0;
    end
    it.sl = nsl; it.me = nme; it.tag = tag;
    q.push_back(it);
    m_sleep = nsl;
  endtask

  task automatic hold(input int n, input logic s, input logic d, input logic e, input string tag);
    for (int i = 0; i < n; i++) cyc(s, d, e, tag);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.sl, it.me, it.tag);
      end
    end
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 1'b1, "R8 reset");
    rst = 1'b0;
    hold(2, 1, 1, 0, "R8 idle");
    hold(WIN + 15, 0, 0, 0, "R2 disabled");
    hold(2, 1, 1, 1, "R1 setup");
    hold(WIN, 0, 0, 1, "R1 window short");
    cyc(1, 0, 1, "R1 one edge short");
    hold(WIN, 0, 0, 1, "R1 window");
    cyc(0, 0, 1, "R1 R5 entry edge");
    hold(3, 0, 0, 1, "R5 asleep");
    hold(5, 0, 0, 0, "R4 enable cleared");
    cyc(0, 1, 0, "R3 wake sda");
    cyc(1, 1, 1, "R6 meas back");
    hold(2, 1, 1, 1, "R6 active");
    hold(12, 0, 0, 1, "R7 part");
    cyc(1, 0, 1, "R7 glitch");
    hold(WIN, 0, 0, 1, "R7 restart");
    cyc(0, 0, 1, "R7 entry");
    cyc(1, 0, 1, "R3 wake scl");
    cyc(0, 0, 1, "R6 meas back");
    hold(10, 0, 0, 1, "R7 part");
    cyc(0, 0, 0, "R7 enable drop");
    hold(WIN + 1, 0, 0, 1, "R7 after drop");
    hold(2, 0, 0, 1, "R5 asleep");
    hold(3, 1, 1, 1, "R3 wake");
    repeat (3) @(posedge clk);
    #6;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule